// File: doc/BRIEF.md
# Parallel GPIO Port Controller

An eight-pin general-purpose port sits between a simple register bus and the pad cells. Software owns two registers: a data latch that holds the values driven out, and a direction register. Each pin may also be handed to a digital peripheral, which then drives the pad, or to an analog function, which turns off both of the pin's pad buffers. For every pin the block produces an output enable, an output value and an input-buffer enable.

Pad inputs are brought into the bus clock domain through a two-stage flip-flop chain before any read can see them. A read of the data register returns a value for each pin according to that pin's direction bit, whoever drives the pin. An output pin returns the latch bit. An input pin returns the synchronized pad value, or 0 when its input buffer is off. A pin can be marked output-only at build time; its input buffer is then never on.

Top module: `gpio_port`

## Requirements
- R1: After reset the data latch and the direction register are 0. Every pad output enable is low, and reads of both registers return 0 while the pad inputs are low.
- R2: With no alternate or analog function on a pin, a direction bit of 1 raises that pin's pad_oe and drives pad_do from the latch bit. A direction bit of 0 leaves pad_oe low.
- R3: A read at address 0 (data) returns the latch bit for every pin whose direction bit is 1.
- R4: A read at address 0 returns the pad input for a pin whose direction bit is 0 and whose input buffer is on. The value is seen through a two-flop synchronizer, so a change on pad_in is first visible two bus-clock edges later.
- R5: A write to address 0 updates the latch whatever the direction bits are. A value written while a pin is an input appears on pad_do and is read back once the pin becomes an output.
- R6: When alt_en is set on a pin and ana_en is clear, pad_oe follows alt_oe and pad_do follows alt_do. The data read for that pin still follows its direction bit.
- R7: When ana_en is set on a pin, pad_oe, pad_do and pad_ibe are all 0 for that pin. If that pin's direction bit is 0, the pin reads 0.
- R8: When ana_en and alt_en are both set on a pin, the analog rule of R7 applies and the alternate function has no effect on the pad.
- R9: A pin marked in the OUT_ONLY parameter mask always has pad_ibe low and reads 0 while its direction bit is 0.
- R10: A write to address 1 (direction) updates the direction register, and a read at address 1 returns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register select: 0 data, 1 direction |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Combinational read data for the selected register |
| alt_en | input | W | Per-pin alternate digital function enable |
| alt_oe | input | W | Output enable from the alternate function |
| alt_do | input | W | Output data from the alternate function |
| ana_en | input | W | Per-pin analog function enable |
| pad_in | input | W | Raw pad input values |
| pad_oe | output | W | Per-pin pad output-buffer enable |
| pad_do | output | W | Per-pin pad output data |
| pad_ibe | output | W | Per-pin pad input-buffer enable |

## Verification
The read path is driven with a mix of directions, so the latch bits and the pad bits are told apart: latch 0xA5 against pad values 0xF0 and 0x5A. The bench watches the pad-to-read delay edge by edge, which catches a synchronizer that is one stage short or one stage long. The pad side is then tried with the alternate function alone, with analog on other pins, and with analog and alternate on the same pins. These cases separate the override order from the read-source rule. A second reset late in the run shows that the state returns to its cleared values.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic {
        REG_DATA = 1'b0,
        REG_DIR  = 1'b1
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_in;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  gpio_reg_e    wr_sel,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] dat_q,
    output logic [W-1:0] dir_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
            dir_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                REG_DATA: dat_q <= wr_val;
                REG_DIR:  dir_q <= wr_val;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl #(
    parameter bit OUT_ONLY = 1'b0
) (
    input  logic dir,
    input  logic dat,
    input  logic alt_en,
    input  logic alt_oe,
    input  logic alt_do,
    input  logic ana_en,
    input  logic sync_in,
    output logic oe,
    output logic dout,
    output logic ibe,
    output logic rd_bit
);
    // Owner of the pad: analog first, then the peripheral, then the port.
    always_comb begin
        if (ana_en) begin
            oe   = 1'b0;
            dout = 1'b0;
        end else if (alt_en) begin
            oe   = alt_oe;
            dout = alt_do;
        end else begin
            oe   = dir;
            dout = dat;
        end
        ibe = !ana_en && !OUT_ONLY;
        // The read source follows the direction bit, never the pad owner.
        if (dir)      rd_bit = dat;
        else if (ibe) rd_bit = sync_in;
        else          rd_bit = 1'b0;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int           W        = 8,
    parameter int           SYNC_LEN = 2,
    parameter logic [W-1:0] OUT_ONLY = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_addr,
    input  logic         bus_we,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] alt_en,
    input  logic [W-1:0] alt_oe,
    input  logic [W-1:0] alt_do,
    input  logic [W-1:0] ana_en,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_do,
    output logic [W-1:0] pad_ibe
);
    gpio_reg_e    sel;
    logic [W-1:0] dat_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pad_s;
    logic [W-1:0] rd_vec;

    assign sel = gpio_reg_e'(bus_addr);

    gpio_regs #(.W(W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_we),
        .wr_sel (sel),
        .wr_val (bus_wdata),
        .dat_q  (dat_q),
        .dir_q  (dir_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .d_out (pad_s)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        gpio_pin_ctl #(.OUT_ONLY(OUT_ONLY[i])) u_pin (
            .dir     (dir_q[i]),
            .dat     (dat_q[i]),
            .alt_en  (alt_en[i]),
            .alt_oe  (alt_oe[i]),
            .alt_do  (alt_do[i]),
            .ana_en  (ana_en[i]),
            .sync_in (pad_s[i]),
            .oe      (pad_oe[i]),
            .dout    (pad_do[i]),
            .ibe     (pad_ibe[i]),
            .rd_bit  (rd_vec[i])
        );
    end

    always_comb begin
        unique case (sel)
            REG_DATA: bus_rdata = rd_vec;
            REG_DIR:  bus_rdata = dir_q;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_addr,
    input logic         bus_we,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] alt_en,
    input logic [W-1:0] alt_oe,
    input logic [W-1:0] ana_en,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_ibe,
    input logic [W-1:0] dat_q,
    input logic [W-1:0] dir_q
);
    logic [1:0] up;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          up <= '0;
        else if (up != 2'd2) up <= up + 2'd1;
    end

    a_r3_out_reads_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 1'b0) |-> (((bus_rdata ^ dat_q) & dir_q) == '0));

    a_r4_sync_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (up == 2'd2 && bus_addr == 1'b0)
        |-> (((bus_rdata ^ $past(pad_in, 2)) & ~dir_q & pad_ibe) == '0));

    a_r6_alt_owns_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe ^ alt_oe) & alt_en & ~ana_en) == '0));

    a_r7_analog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((ana_en & (pad_oe | pad_ibe)) == '0));

    a_r10_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 1'b1) |=> (dir_q == $past(bus_wdata)));
endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .alt_en    (alt_en),
    .alt_oe    (alt_oe),
    .ana_en    (ana_en),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_ibe   (pad_ibe),
    .dat_q     (dat_q),
    .dir_q     (dir_q)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_addr = 1'b0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] alt_en = '0;
    logic [W-1:0] alt_oe = '0;
    logic [W-1:0] alt_do = '0;
    logic [W-1:0] ana_en = '0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_do;
    logic [W-1:0] pad_ibe;

    always #2.5 clk = ~clk;

    gpio_port #(.W(W), .SYNC_LEN(2), .OUT_ONLY(8'h80)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_en(alt_en),
        .alt_oe(alt_oe), .alt_do(alt_do), .ana_en(ana_en), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_do(pad_do), .pad_ibe(pad_ibe)
    );

    typedef struct {
        int         sel;   // 0 rdata, 1 pad_oe, 2 pad_do, 3 pad_ibe
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // Monitor: compares every queued expectation at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.sel)
                0:       act = bus_rdata;
                1:       act = pad_oe;
                2:       act = pad_do;
                default: act = pad_ibe;
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic expect_v(input int sel, input logic [7:0] exp, input string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        bus_addr = 1'b0;
        expect_v(0, 8'h00, "R1 data read");
        expect_v(1, 8'h00, "R1 pad_oe");
        expect_v(3, 8'h7F, "R9 ibe out-only");
        step();
        bus_addr = 1'b1;
        expect_v(0, 8'h00, "R1 dir read");
        step();

        // R5 preload latch with all pins input
        bus_write(1'b0, 8'hA5);
        bus_addr = 1'b0;
        expect_v(1, 8'h00, "R5 still no drive");
        expect_v(2, 8'hA5, "R5 latch on pad_do");
        expect_v(0, 8'h00, "R5 inputs read pad");
        step();

        // R10 / R2 / R3 low nibble output
        bus_write(1'b1, 8'h0F);
        bus_addr = 1'b1;
        expect_v(0, 8'h0F, "R10 dir readback");
        step();
        bus_addr = 1'b0;
        expect_v(0, 8'h05, "R3 latch read");
        expect_v(1, 8'h0F, "R2 pad_oe");
        expect_v(2, 8'hA5, "R2 pad_do");
        step();

        // R4 synchronizer latency, R9 out-only reads 0
        pad_in = 8'hF0;
        expect_v(0, 8'h05, "R4 edge0");
        step();
        expect_v(0, 8'h05, "R4 edge1");
        step();
        expect_v(0, 8'h75, "R4 edge2 R9");
        pad_in = 8'h5A;
        step();
        step();
        expect_v(0, 8'h55, "R4 pattern 5A");
        step();

        // R6 alternate function
        alt_en = 8'h3C; alt_oe = 8'h30; alt_do = 8'hFF;
        expect_v(1, 8'h33, "R6 pad_oe");
        expect_v(2, 8'hBD, "R6 pad_do");
        expect_v(0, 8'h55, "R6 read follows dir");
        step();

        // R7 analog on pins 0 and 6
        ana_en = 8'h41;
        expect_v(1, 8'h32, "R7 pad_oe");
        expect_v(2, 8'hBC, "R7 pad_do");
        expect_v(3, 8'h3E, "R7 pad_ibe");
        expect_v(0, 8'h15, "R7 input reads 0");
        step();

        // R8 analog and alternate on same pins
        ana_en = 8'h3C;
        expect_v(1, 8'h03, "R8 pad_oe");
        expect_v(2, 8'h81, "R8 pad_do");
        expect_v(3, 8'h43, "R8 pad_ibe");
        expect_v(0, 8'h45, "R8 read");
        step();

        // R1 reset again
        alt_en = '0; ana_en = '0; pad_in = '0;
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        bus_addr = 1'b1;
        expect_v(0, 8'h00, "R1 dir after reset");
        expect_v(1, 8'h00, "R1 oe after reset");
        step();
        bus_addr = 1'b0;
        expect_v(2, 8'h00, "R1 latch after reset");
        step();
        step();

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule